// File: doc/BRIEF.md
# Watchdog and Power-Fail Reset Supervisor

This block supervises a processor from two digital inputs: a power-good flag coming from an external supply comparator, and a strobe that software must keep toggling. When power-good drops, the block raises an interrupt warning first. If the supply stays bad for a set number of ticks, it then asserts the processor reset. The chip enable for an external SRAM is blocked as soon as power-good falls, which write-protects that memory. Once the supply is back, reset is held for a fixed stabilisation window and then released.

A watchdog runs beside the power path. It counts slow timebase ticks, and the 32.768 kHz rate is the intended source. Any edge on the strobe restarts the count; the strobe passes through a two-flop synchroniser first. If the count reaches the selected limit, the block asserts a watchdog output and the shared reset for the same stabilisation window. After that window the watchdog starts a new period. An enable input stands in for a strobe pin that is left unconnected.

The default parameters give a 200 ms stabilisation window, a 10 ms delay from warning to reset, and watchdog limits of 1.5 s, 0.75 s, 0.375 s and 0.1875 s.

Top module: `wdpf_supervisor`

## Requirements
- R1: After the asynchronous reset, `rst_o` is 1 and both `int_o` and `wdo_o` are 0. With power-good high, `rst_o` is released after HOLD_TICKS ticks.
- R2: One clock after power-good falls, `int_o` is 1, while `rst_o` stays 0 during the warning.
- R3: If power-good stays low for WARN_TICKS ticks, `rst_o` asserts, and `int_o` remains 1 for as long as power-good stays low.
- R4: If power-good returns before the warning delay ends, `int_o` clears on the next clock and `rst_o` is never asserted.
- R5: Once `rst_o` has been asserted by the power path, it does not deassert while power-good is low.
- R6: After power-good returns from a power reset, `int_o` clears on the next clock, and `rst_o` stays 1 for HOLD_TICKS ticks before it is released.
- R7: `ce_n_o` equals `ce_n_i` while power-good is high. It is forced to 1 (inactive) in the same cycle that power-good is low, with no clock in between.
- R8: The watchdog limit is set by `wd_sel_i`: 0 gives 8×WD_BASE_TICKS, 1 gives 4×, 2 gives 2× and 3 gives 1× ticks. If the strobe shows no edge for that long, `wdo_o` and `rst_o` assert together.
- R9: A rising or falling edge on `wdi_i` restarts the watchdog count. Edges spaced closer than the limit keep `wdo_o` at 0.
- R10: While `wd_en_i` is 0, the watchdog count is held at zero and `wdo_o` stays 0.
- R11: A watchdog pulse holds `wdo_o` and `rst_o` for HOLD_TICKS ticks. When the pulse ends, the watchdog restarts and times out again after one full limit if there is no strobe edge.
- R12: While the power path holds reset, the watchdog is cleared and `wdo_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle timebase tick (nominally 32.768 kHz) |
| pwr_good_i | input | 1 | Supply in tolerance, from the external comparator |
| ce_n_i | input | 1 | System SRAM chip enable, active low |
| wdi_i | input | 1 | Watchdog strobe, asynchronous |
| wd_en_i | input | 1 | Watchdog enable (0 = strobe unconnected) |
| wd_sel_i | input | 2 | Watchdog limit code |
| int_o | output | 1 | Power-fail interrupt warning, active high |
| rst_o | output | 1 | Processor reset, active high |
| wdo_o | output | 1 | Watchdog fault output, active high |
| ce_n_o | output | 1 | Gated SRAM chip enable, active low |

## Verification
The bench drops power-good briefly and then for a long time. A design that resets during a short glitch, or that skips the warning, fails the R2 and R4 checks. A design that lets reset go while the supply is still bad fails R5. The bench drives the chip enable at the exact moment power-good falls, so gating that waits for a clock edge shows up as a one-cycle leak. It measures the watchdog limit for every code and the restart after a watchdog pulse. It also feeds random strobe spacing below the limit, and holds the strobe still both with the watchdog disabled and during a power reset. A wrong limit decode, a missed edge polarity or a counter that is not cleared during reset each produces a spurious or mistimed `wdo_o`.

// File: rtl/sup_pkg.sv
package sup_pkg;

  typedef enum logic [1:0] {
    PS_RUN  = 2'd0,
    PS_WARN = 2'd1,
    PS_DOWN = 2'd2,
    PS_HOLD = 2'd3
  } pwr_state_t;

  // A larger code selects a shorter limit: the shift counts doublings of the base.
  function automatic logic [1:0] wd_shift(input logic [1:0] sel);
    return 2'd3 - sel;
  endfunction

endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic edge_o
);

  // sh_q[STAGES-1:0] is the synchroniser chain; sh_q[STAGES] holds the previous synchronised value.
  logic [STAGES:0] sh_q, sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-1:0], d_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign edge_o = sh_q[STAGES] ^ sh_q[STAGES-1];

endmodule

// File: rtl/sup_pwr_fsm.sv
module sup_pwr_fsm
  import sup_pkg::*;
#(
  parameter int WARN_TICKS = 328,
  parameter int HOLD_TICKS = 6554
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic pg_i,
  output logic warn_o,
  output logic prst_o
);

  localparam int CMAX = (WARN_TICKS > HOLD_TICKS) ? WARN_TICKS : HOLD_TICKS;
  localparam int CW   = $clog2(CMAX + 1);
  localparam logic [CW-1:0] WARN_LAST = CW'(WARN_TICKS - 1);
  localparam logic [CW-1:0] HOLD_LAST = CW'(HOLD_TICKS - 1);

  pwr_state_t    st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    case (st_q)
      PS_RUN: begin
        if (!pg_i) begin
          st_d  = PS_WARN;
          cnt_d = '0;
        end
      end
      PS_WARN: begin
        if (pg_i) begin
          st_d = PS_RUN;
        end else if (tick_i) begin
          if (cnt_q == WARN_LAST) begin
            st_d  = PS_DOWN;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      PS_DOWN: begin
        if (pg_i) begin
          st_d  = PS_HOLD;
          cnt_d = '0;
        end
      end
      PS_HOLD: begin
        if (!pg_i) begin
          st_d = PS_DOWN;
        end else if (tick_i) begin
          if (cnt_q == HOLD_LAST) st_d = PS_RUN;
          else                    cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        st_d  = PS_HOLD;
        cnt_d = '0;
      end
    endcase
  end

  // Power-on enters the stabilisation window directly.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PS_HOLD;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign warn_o = (st_q == PS_WARN) || (st_q == PS_DOWN);
  assign prst_o = (st_q == PS_DOWN) || (st_q == PS_HOLD);

  // R5
  rst_hold_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prst_o && !pg_i) |=> prst_o);

  // R2
  rst_after_warn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prst_o) |-> $past(warn_o));

  // R4
  warn_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pg_i |=> !warn_o);

endmodule

// File: rtl/sup_watchdog.sv
module sup_watchdog
  import sup_pkg::*;
#(
  parameter int WD_BASE_TICKS = 6144,
  parameter int HOLD_TICKS    = 6554
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       en_i,
  input  logic [1:0] sel_i,
  input  logic       kick_i,
  input  logic       clr_i,
  output logic       wdo_o
);

  localparam int WCW = $clog2(WD_BASE_TICKS * 8 + 1);
  localparam int HCW = $clog2(HOLD_TICKS + 1);
  localparam logic [HCW-1:0] HOLD_LAST = HCW'(HOLD_TICKS - 1);

  logic [WCW-1:0] cnt_q, cnt_d;
  logic [HCW-1:0] hcnt_q, hcnt_d;
  logic           hold_q, hold_d;
  logic [WCW-1:0] limit_m1;

  always_comb begin
    limit_m1 = (WCW'(WD_BASE_TICKS) << wd_shift(sel_i)) - 1'b1;
  end

  always_comb begin
    cnt_d  = cnt_q;
    hcnt_d = hcnt_q;
    hold_d = hold_q;
    if (clr_i) begin
      cnt_d  = '0;
      hcnt_d = '0;
      hold_d = 1'b0;
    end else if (hold_q) begin
      if (tick_i) begin
        if (hcnt_q == HOLD_LAST) begin
          hold_d = 1'b0;
          cnt_d  = '0;
        end else begin
          hcnt_d = hcnt_q + 1'b1;
        end
      end
    end else if (!en_i || kick_i) begin
      cnt_d = '0;
    end else if (tick_i) begin
      if (cnt_q >= limit_m1) begin
        hold_d = 1'b1;
        hcnt_d = '0;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      hcnt_q <= '0;
      hold_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      hcnt_q <= hcnt_d;
      hold_q <= hold_d;
    end
  end

  assign wdo_o = hold_q;

  // R10
  wd_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !wdo_o) |=> !wdo_o);

  // R12
  wd_clr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !wdo_o);

endmodule

// File: rtl/wdpf_supervisor.sv
module wdpf_supervisor #(
  parameter int WARN_TICKS    = 328,
  parameter int HOLD_TICKS    = 6554,
  parameter int WD_BASE_TICKS = 6144,
  parameter int SYNC_STAGES   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       pwr_good_i,
  input  logic       ce_n_i,
  input  logic       wdi_i,
  input  logic       wd_en_i,
  input  logic [1:0] wd_sel_i,
  output logic       int_o,
  output logic       rst_o,
  output logic       wdo_o,
  output logic       ce_n_o
);

  logic warn_w, prst_w, kick_w, wdo_w;

  sup_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_i    (wdi_i),
    .edge_o (kick_w)
  );

  sup_pwr_fsm #(.WARN_TICKS(WARN_TICKS), .HOLD_TICKS(HOLD_TICKS)) u_pwr (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (tick_i),
    .pg_i   (pwr_good_i),
    .warn_o (warn_w),
    .prst_o (prst_w)
  );

  sup_watchdog #(.WD_BASE_TICKS(WD_BASE_TICKS), .HOLD_TICKS(HOLD_TICKS)) u_wd (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (tick_i),
    .en_i   (wd_en_i),
    .sel_i  (wd_sel_i),
    .kick_i (kick_w),
    .clr_i  (prst_w),
    .wdo_o  (wdo_w)
  );

  assign int_o  = warn_w;
  assign rst_o  = prst_w | wdo_w;
  assign wdo_o  = wdo_w;
  assign ce_n_o = ce_n_i | ~pwr_good_i;

endmodule

// File: tb/tb_wdpf_supervisor.sv
module tb_wdpf_supervisor;

  localparam int W = 6;
  localparam int H = 10;
  localparam int B = 8;

  logic clk = 1'b0;
  logic tick = 1'b0;
  logic rst_n, pg, ce_n_i, wdi, wd_en;
  logic [1:0] wd_sel;
  logic int_o, rst_o, wdo_o, ce_n_o;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;
  always @(posedge clk) tick <= ~tick;

  wdpf_supervisor #(.WARN_TICKS(W), .HOLD_TICKS(H), .WD_BASE_TICKS(B)) dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .pwr_good_i(pg), .ce_n_i(ce_n_i),
    .wdi_i(wdi), .wd_en_i(wd_en), .wd_sel_i(wd_sel),
    .int_o(int_o), .rst_o(rst_o), .wdo_o(wdo_o), .ce_n_o(ce_n_o));

  function automatic int wd_limit(input int sel);
    return B << (3 - sel);
  endfunction

  function automatic logic pick(input int which);
    case (which)
      0: return rst_o;
      1: return int_o;
      default: return wdo_o;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_level(input int which, input logic val, input int maxc, output int n);
    n = 0;
    while (pick(which) !== val && n < maxc) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic in_win(input string req, input int n, input int lo, input int hi);
    check(n >= lo && n <= hi, req, n, lo);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL timeout: run hung, actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n, bad, seed;
    seed = $urandom(32'h5EED1234);
    rst_n = 0; pg = 1; ce_n_i = 1; wdi = 0; wd_en = 0; wd_sel = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    check(rst_o == 1, "R1 rst after reset", rst_o, 1);
    check(int_o == 0 && wdo_o == 0, "R1 int/wdo after reset", {int_o, wdo_o}, 0);
    wait_level(0, 1'b0, 200, n);
    in_win("R1 power-on hold cycles", n, 2*H-2, 2*H+3);

    // R7 random chip enable passthrough while power is good
    bad = 0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      ce_n_i = 1'($urandom);
      #1;
      if (ce_n_o !== ce_n_i) bad++;
    end
    check(bad == 0, "R7 passthrough mismatches", bad, 0);

    // Long power failure
    @(negedge clk);
    ce_n_i = 0; pg = 0;
    #1;
    check(ce_n_o == 1, "R7 ce forced same cycle", ce_n_o, 1);
    @(negedge clk);
    check(int_o == 1, "R2 int after fall", int_o, 1);
    check(rst_o == 0, "R2 no reset during warning", rst_o, 0);
    wait_level(0, 1'b1, 200, n);
    in_win("R3 warn-to-reset cycles", n + 1, 2*W-2, 2*W+3);
    check(int_o == 1, "R3 int held with reset", int_o, 1);
    wd_en = 1; wd_sel = 3;
    bad = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (rst_o !== 1) bad++;
      if (wdo_o !== 0) bad += 100;
    end
    check(bad < 100, "R12 wdo during power reset", bad, 0);
    check(bad % 100 == 0, "R5 reset held while low", bad, 0);
    check(ce_n_o == 1, "R7 ce blocked during outage", ce_n_o, 1);
    wd_en = 0; pg = 1;
    @(negedge clk);
    check(int_o == 0, "R6 int clears on return", int_o, 1'b0);
    wait_level(0, 1'b0, 200, n);
    in_win("R6 stabilisation cycles", n + 1, 2*H-2, 2*H+3);

    // Short glitch
    @(negedge clk);
    pg = 0;
    bad = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (rst_o !== 0) bad++;
    end
    pg = 1;
    @(negedge clk);
    check(int_o == 0, "R4 int clears after glitch", int_o, 0);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (rst_o !== 0) bad++;
    end
    check(bad == 0, "R4 no reset from glitch", bad, 0);

    // Watchdog disabled
    bad = 0;
    for (int i = 0; i < 150; i++) begin
      @(negedge clk);
      if (wdo_o !== 0 || rst_o !== 0) bad++;
    end
    check(bad == 0, "R10 disabled watchdog quiet", bad, 0);

    // Timeout per code
    for (int s = 0; s < 4; s++) begin
      @(negedge clk);
      wd_sel = 2'(s); wd_en = 1; wdi = ~wdi;
      wait_level(2, 1'b1, 600, n);
      in_win($sformatf("R8 limit sel=%0d", s), n, 2*wd_limit(s)-4, 2*wd_limit(s)+6);
      check(rst_o == 1, "R8 reset with wdo", rst_o, 1);
      wait_level(2, 1'b0, 200, n);
      in_win("R11 watchdog pulse length", n, 2*H-2, 2*H+3);
      check(rst_o == 0, "R11 reset released with wdo", rst_o, 0);
      if (s == 3) begin
        wait_level(2, 1'b1, 600, n);
        in_win("R11 restart after pulse", n, 2*wd_limit(s)-4, 2*wd_limit(s)+6);
        wait_level(2, 1'b0, 200, n);
      end
      wd_en = 0;
      @(negedge clk);
    end

    // R9 random strobe spacing below the limit
    for (int r = 0; r < 4; r++) begin
      int lim;
      wd_sel = 2'($urandom_range(0, 3));
      lim = wd_limit(wd_sel);
      wd_en = 1;
      bad = 0;
      for (int k = 0; k < 12; k++) begin
        int gap;
        gap = $urandom_range(1, lim - 3);
        wdi = ~wdi;
        for (int c = 0; c < 2 * gap; c++) begin
          @(negedge clk);
          if (wdo_o !== 0) bad++;
        end
      end
      check(bad == 0, $sformatf("R9 kicked watchdog quiet sel=%0d", wd_sel), bad, 0);
      wd_en = 0;
      @(negedge clk);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule